// File: doc/BRIEF.md
# Segmented persistent data port

This block connects a 16-bit data bus to four 64-bit resources: a comparand register, two mask registers and a window onto one memory word. A 64-bit resource is moved one 16-bit segment at a time, with segment k holding bits 16k+15 down to 16k. Reads and writes are routed separately. A source selector picks the resource that data reads see, and a destination selector picks the resource that data writes fill. Each selector keeps its value across any number of accesses until a new select command of its own kind arrives.

Each side has its own segment counter. The counter steps once per access and wraps from the last segment back to segment 0. When the last segment of the comparand or of either mask is written, the block raises a one-cycle compare-trigger pulse, so that a finished pattern or mask can start a search in the neighbouring compare logic. Writes to memory collect in a 64-bit staging word. After the last segment arrives, a word write strobe is issued. Instruction decode and bus tristating are outside this block. Decoded select commands and access strobes arrive as single-cycle inputs.

Top module: `seg_data_port`

## Requirements
- R1: After reset, src_code and dst_code read 00. Both segment counters are 0. The comparand, the mask registers and mem_wdata are all zero, and cmp_trig and mem_we are low.
- R2: A cycle with wr_stb high (and sel_dst_vld low) stores wr_data into the current destination segment of the selected destination. Segment k is bits 16k+15:16k. The destination counter then moves to the next segment and wraps from 3 to 0.
- R3: rd_data shows, in the same cycle, the current source segment of the selected source. A cycle with rd_stb high (and sel_src_vld low) moves the source counter to the next segment, and it wraps from 3 to 0.
- R4: sel_src_vld loads sel_code into src_code, and sel_dst_vld loads sel_code into dst_code. The counter of that side returns to segment 0. The encoding is 00 comparand, 01 mask 1, 10 mask 2, 11 memory.
- R5: A select command or an access on one side changes neither the code nor the segment counter of the other side.
- R6: cmp_trig goes high for exactly the one cycle after a write to segment 3 of the comparand, mask 1 or mask 2. It stays low for writes to other segments and for any write to memory.
- R7: Writes routed to memory fill mem_wdata segment by segment. A write to segment 3 raises mem_we for one cycle after that write, with the complete word on mem_wdata.
- R8: With source 11, rd_data shows the current source segment of mem_rdata.
- R9: A select command given in the same cycle as that side's strobe wins. The strobe has no effect: nothing is written and the counter is not advanced.
- R10: A write changes only the selected resource. The other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_src_vld | input | 1 | Select-source command strobe |
| sel_dst_vld | input | 1 | Select-destination command strobe |
| sel_code | input | 2 | Resource code for a select command |
| wr_stb | input | 1 | Data write cycle strobe |
| wr_data | input | 16 | Write data segment |
| rd_stb | input | 1 | Data read cycle strobe |
| rd_data | output | 16 | Read data segment |
| src_code | output | 2 | Current source code |
| dst_code | output | 2 | Current destination code |
| cmp_trig | output | 1 | Compare-trigger pulse |
| cmp_q | output | 64 | Comparand register |
| mk1_q | output | 64 | Mask register 1 |
| mk2_q | output | 64 | Mask register 2 |
| mem_rdata | input | 64 | Memory word read data |
| mem_wdata | output | 64 | Memory word write data |
| mem_we | output | 1 | Memory word write strobe |

## Verification
The hardest case to reach is a selector that is rewritten while its counter sits partway through a word, and in particular a select command that lands in the same cycle as an access strobe. The stimulus writes two segments of mask 2 and then selects mask 2 again, so the next four writes must start over at segment 0. It then drives a destination select together with a write strobe carrying a marker value, and checks that the marker appears nowhere and that the following write lands in segment 0. Trigger absence for memory writes is checked by watching cmp_trig across a full memory word.

// File: rtl/seg_port_pkg.sv
package seg_port_pkg;
  typedef enum logic [1:0] {
    RES_CMP = 2'b00,
    RES_MK1 = 2'b01,
    RES_MK2 = 2'b10,
    RES_MEM = 2'b11
  } res_e;
  localparam int NUM_RES = 4;
endpackage

// File: rtl/seg_sel_ctr.sv
module seg_sel_ctr
  import seg_port_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int CNT_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_vld,
  input  res_e             sel_code,
  input  logic             stb,
  output res_e             code,
  output logic [CNT_W-1:0] seg
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SEG - 1);

  res_e             code_d;
  logic [CNT_W-1:0] seg_d;
  logic             code_en;
  logic             seg_en;

  always_comb begin
    code_en = sel_vld;
    code_d  = sel_code;
    seg_en  = sel_vld | stb;
    if (sel_vld)          seg_d = '0;
    else if (seg == LAST) seg_d = '0;
    else                  seg_d = seg + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= RES_CMP;
      seg  <= '0;
    end else begin
      if (code_en) code <= code_d;
      if (seg_en)  seg  <= seg_d;
    end
  end

  assert_sel_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |=> (code == $past(sel_code)) && (seg == '0));
  assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !sel_vld && seg == LAST) |=> seg == '0);
  assert_step_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !sel_vld && seg != LAST) |=> seg == $past(seg) + 1'b1);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !sel_vld) |=> $stable(seg) && $stable(code));
endmodule

// File: rtl/seg_word_bank.sv
module seg_word_bank
  import seg_port_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  localparam int WORD_W = SEG_W * NUM_SEG,
  localparam int CNT_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  res_e              wr_res,
  input  logic [CNT_W-1:0]  wr_seg,
  input  logic [SEG_W-1:0]  wr_data,
  output logic [WORD_W-1:0] cmp_q,
  output logic [WORD_W-1:0] mk1_q,
  output logic [WORD_W-1:0] mk2_q,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              cmp_trig
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SEG - 1);

  logic [WORD_W-1:0] word_q [NUM_RES];
  logic              last_wr;
  logic              trig_d;
  logic              we_d;

  for (genvar r = 0; r < NUM_RES; r++) begin : g_word
    logic              en;
    logic [WORD_W-1:0] word_d;

    always_comb begin
      en     = wr_en && (wr_res == res_e'(r));
      word_d = word_q[r];
      word_d[wr_seg*SEG_W +: SEG_W] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q[r] <= '0;
      else if (en) word_q[r] <= word_d;
    end
  end

  always_comb begin
    last_wr = wr_en && (wr_seg == LAST);
    trig_d  = last_wr && (wr_res != RES_MEM);
    we_d    = last_wr && (wr_res == RES_MEM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_trig <= 1'b0;
      mem_we   <= 1'b0;
    end else begin
      cmp_trig <= trig_d;
      mem_we   <= we_d;
    end
  end

  assign cmp_q     = word_q[RES_CMP];
  assign mk1_q     = word_q[RES_MK1];
  assign mk2_q     = word_q[RES_MK2];
  assign mem_wdata = word_q[RES_MEM];

  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_trig |=> !cmp_trig);
  assert_trig_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_trig |-> $past(wr_en) && ($past(wr_seg) == LAST) && ($past(wr_res) != RES_MEM));
  assert_mem_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_en) && ($past(wr_seg) == LAST) && ($past(wr_res) == RES_MEM));
  assert_no_trig_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && cmp_trig));
  assert_cmp_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_res == RES_CMP) |=> $stable(mk1_q) && $stable(mk2_q) && $stable(mem_wdata));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmp_q) && $stable(mk1_q) && $stable(mk2_q));
endmodule

// File: rtl/seg_rd_mux.sv
module seg_rd_mux
  import seg_port_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  localparam int WORD_W = SEG_W * NUM_SEG,
  localparam int CNT_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  res_e              src,
  input  logic [CNT_W-1:0]  seg,
  input  logic [WORD_W-1:0] cmp_q,
  input  logic [WORD_W-1:0] mk1_q,
  input  logic [WORD_W-1:0] mk2_q,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [SEG_W-1:0]  rd_data
);
  logic [WORD_W-1:0] word;

  always_comb begin
    unique case (src)
      RES_CMP: word = cmp_q;
      RES_MK1: word = mk1_q;
      RES_MK2: word = mk2_q;
      default: word = mem_rdata;
    endcase
    rd_data = word[seg*SEG_W +: SEG_W];
  end
endmodule

// File: rtl/seg_data_port.sv
module seg_data_port
  import seg_port_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  localparam int WORD_W = SEG_W * NUM_SEG,
  localparam int CNT_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_src_vld,
  input  logic              sel_dst_vld,
  input  logic [1:0]        sel_code,
  input  logic              wr_stb,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              rd_stb,
  output logic [SEG_W-1:0]  rd_data,
  output logic [1:0]        src_code,
  output logic [1:0]        dst_code,
  output logic              cmp_trig,
  output logic [WORD_W-1:0] cmp_q,
  output logic [WORD_W-1:0] mk1_q,
  output logic [WORD_W-1:0] mk2_q,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we
);
  res_e             src_res;
  res_e             dst_res;
  logic [CNT_W-1:0] src_seg;
  logic [CNT_W-1:0] dst_seg;
  logic             wr_en;
  logic             rd_en;

  assign wr_en = wr_stb & ~sel_dst_vld;
  assign rd_en = rd_stb & ~sel_src_vld;

  seg_sel_ctr #(.NUM_SEG(NUM_SEG)) u_src_ctr (
    .clk(clk), .rst_n(rst_n), .sel_vld(sel_src_vld), .sel_code(res_e'(sel_code)),
    .stb(rd_en), .code(src_res), .seg(src_seg)
  );

  seg_sel_ctr #(.NUM_SEG(NUM_SEG)) u_dst_ctr (
    .clk(clk), .rst_n(rst_n), .sel_vld(sel_dst_vld), .sel_code(res_e'(sel_code)),
    .stb(wr_en), .code(dst_res), .seg(dst_seg)
  );

  seg_word_bank #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_res(dst_res), .wr_seg(dst_seg),
    .wr_data(wr_data), .cmp_q(cmp_q), .mk1_q(mk1_q), .mk2_q(mk2_q),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .cmp_trig(cmp_trig)
  );

  seg_rd_mux #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_rd_mux (
    .src(src_res), .seg(src_seg), .cmp_q(cmp_q), .mk1_q(mk1_q), .mk2_q(mk2_q),
    .mem_rdata(mem_rdata), .rd_data(rd_data)
  );

  assign src_code = src_res;
  assign dst_code = dst_res;

  assert_sides_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_src_vld && !sel_dst_vld) |=> $stable(dst_code));
  assert_strobe_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_dst_vld && wr_stb) |=> $stable(cmp_q) && $stable(mk1_q) && $stable(mk2_q) && !cmp_trig);
endmodule

// File: tb/seg_data_port_tb.sv
`timescale 1ns/1ps
module seg_data_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_src_vld, sel_dst_vld, wr_stb, rd_stb;
  logic [1:0]  sel_code;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [1:0]  src_code, dst_code;
  logic        cmp_trig, mem_we;
  logic [63:0] cmp_q, mk1_q, mk2_q, mem_rdata, mem_wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  seg_data_port u_dut (
    .clk(clk), .rst_n(rst_n), .sel_src_vld(sel_src_vld), .sel_dst_vld(sel_dst_vld),
    .sel_code(sel_code), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_data(rd_data), .src_code(src_code), .dst_code(dst_code), .cmp_trig(cmp_trig),
    .cmp_q(cmp_q), .mk1_q(mk1_q), .mk2_q(mk2_q), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one data write at a falling edge. Then sample after the next falling edge.
  task automatic wr1(input logic [15:0] d, output logic trig, output logic we);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    #1; trig = cmp_trig; we = mem_we;
  endtask

  task automatic sel(input bit dst, input logic [1:0] c);
    sel_code = c;
    if (dst) sel_dst_vld = 1'b1; else sel_src_vld = 1'b1;
    @(negedge clk);
    sel_dst_vld = 1'b0; sel_src_vld = 1'b0;
  endtask

  task automatic wr_word(input logic [63:0] w, input logic [1:0] c, input string tag);
    logic t, e;
    for (int k = 0; k < 4; k++) begin
      wr1(w[16*k +: 16], t, e);
      chk({63'd0, t}, {63'd0, (k == 3 && c != 2'b11)}, {tag, " R6 trig"});
      chk({63'd0, e}, {63'd0, (k == 3 && c == 2'b11)}, {tag, " R7 we"});
      if (k == 3 && c == 2'b11) chk(mem_wdata, w, {tag, " R7 word"});
    end
    @(negedge clk); #1;
    chk({63'd0, cmp_trig}, 64'd0, {tag, " R6 one-cycle"});
    chk({63'd0, mem_we}, 64'd0, {tag, " R7 one-cycle"});
  endtask

  task automatic rd_word(input logic [63:0] w, input string tag);
    for (int k = 0; k < 5; k++) begin
      #1; chk({48'd0, rd_data}, {48'd0, w[16*(k%4) +: 16]}, tag);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
    end
    sel(1'b0, src_code); // restart the source counter at segment 0
  endtask

  task automatic t_reset();
    #1;
    chk({62'd0, src_code}, 64'd0, "R1 src_code");
    chk({62'd0, dst_code}, 64'd0, "R1 dst_code");
    chk(cmp_q | mk1_q | mk2_q | mem_wdata, 64'd0, "R1 regs");
    chk({62'd0, cmp_trig, mem_we}, 64'd0, "R1 pulses");
    chk({48'd0, rd_data}, 64'd0, "R1 rd_data");
  endtask

  task automatic t_cmp();
    wr_word(64'h1111_2222_3333_4444, 2'b00, "R2 cmp");
    chk(cmp_q, 64'h1111_2222_3333_4444, "R2 cmp word");
    rd_word(64'h1111_2222_3333_4444, "R3 cmp read wrap");
  endtask

  task automatic t_mk1();
    sel(1'b1, 2'b01);
    chk({62'd0, dst_code}, 64'd1, "R4 dst mk1");
    chk({62'd0, src_code}, 64'd0, "R5 src kept");
    wr_word(64'hAAAA_BBBB_CCCC_DDDD, 2'b01, "R2 mk1");
    chk(mk1_q, 64'hAAAA_BBBB_CCCC_DDDD, "R2 mk1 word");
    chk(cmp_q, 64'h1111_2222_3333_4444, "R10 cmp kept");
    chk({48'd0, rd_data}, 64'h4444, "R5 src seg kept");
  endtask

  task automatic t_mk2_restart();
    logic t, e;
    sel(1'b1, 2'b10);
    wr1(16'hDEAD, t, e);
    wr1(16'hBEEF, t, e);
    sel(1'b1, 2'b10);
    wr_word(64'h0123_4567_89AB_CDEF, 2'b10, "R4 mk2 restart");
    chk(mk2_q, 64'h0123_4567_89AB_CDEF, "R4 mk2 word");
    chk(mk1_q, 64'hAAAA_BBBB_CCCC_DDDD, "R10 mk1 kept");
  endtask

  task automatic t_src_sel();
    sel(1'b0, 2'b01);
    chk({62'd0, src_code}, 64'd1, "R4 src mk1");
    chk({62'd0, dst_code}, 64'd2, "R5 dst kept");
    rd_word(64'hAAAA_BBBB_CCCC_DDDD, "R3 mk1 read");
    sel(1'b0, 2'b10);
    rd_word(64'h0123_4567_89AB_CDEF, "R3 mk2 read");
  endtask

  task automatic t_mem();
    sel(1'b1, 2'b11);
    wr_word(64'hFEED_FACE_CAFE_F00D, 2'b11, "R7 mem");
    chk(cmp_q, 64'h1111_2222_3333_4444, "R10 cmp after mem");
    chk(mk2_q, 64'h0123_4567_89AB_CDEF, "R10 mk2 after mem");
    mem_rdata = 64'h5A5A_6B6B_7C7C_8D8D;
    sel(1'b0, 2'b11);
    rd_word(64'h5A5A_6B6B_7C7C_8D8D, "R8 mem read");
  endtask

  task automatic t_collide();
    logic t, e;
    sel_code = 2'b00; sel_dst_vld = 1'b1; wr_stb = 1'b1; wr_data = 16'h9999;
    @(negedge clk);
    sel_dst_vld = 1'b0; wr_stb = 1'b0;
    #1;
    chk(cmp_q, 64'h1111_2222_3333_4444, "R9 cmp unchanged");
    chk(mem_wdata, 64'hFEED_FACE_CAFE_F00D, "R9 mem unchanged");
    chk({62'd0, dst_code}, 64'd0, "R9 select took");
    wr1(16'h7777, t, e);
    chk(cmp_q, 64'h1111_2222_3333_7777, "R9 next write seg0");
    // A read strobe in the same cycle as a source select is lost too.
    sel(1'b0, 2'b00);
    sel_code = 2'b00; sel_src_vld = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    sel_src_vld = 1'b0; rd_stb = 1'b0;
    #1; chk({48'd0, rd_data}, 64'h7777, "R9 read seg0 kept");
  endtask

  initial begin
    rst_n = 1'b0; sel_src_vld = 0; sel_dst_vld = 0; sel_code = 0;
    wr_stb = 0; rd_stb = 0; wr_data = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmp();
    t_mk1();
    t_mk2_restart();
    t_src_sel();
    t_mem();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule